// File: doc/BRIEF.md
# Extended integration shutter timer

This block produces the timing strobes that let an interlaced image sensor integrate light for longer than one field. Each field the sensor's timing generator delivers a one-cycle field tick. In normal mode the block answers every tick with a transfer pulse, which ends the on-chip integration and moves charge into the vertical registers. In low-light mode the transfer is issued only once every 2^k fields. A frame-update strobe travels with each transfer so that the downstream frame buffer refreshes once per integration period. A hold flag tells the buffer to keep showing the previous frame during the fields that have no transfer.

The integration length is never jumped straight to the requested value. The current exponent starts at X1 and climbs one doubling at a time toward the target exponent. A programmable number of complete integration periods must run at each setting before the next doubling, so the picture brightens gradually. The readout clocks, analog chain, video encoding and memory lie outside this block.

Top module: `shutter_ext_timer`

## Requirements
- R1: After reset the transfer pulse, frame-update strobe and hold flag are all 0, the current multiplier is X1 and the field counter is zero.
- R2: With `lowlight_en` low, every field tick produces a transfer pulse. The pulse is high for exactly the one clock cycle that follows the edge sampling the tick.
- R3: `frame_upd` is high in exactly the cycles where `xfer_pulse` is high.
- R4: `xfer_pulse` is never high except in the cycle right after a field tick; idle cycles without ticks produce no transfer.
- R5: At a current multiplier of 2^k, consecutive transfers are exactly 2^k field ticks apart; the field counter clears on each transfer and fires when it reaches 2^k - 1.
- R6: In low-light mode the exponent starts at 0 (X1) and rises by one after `ramp_periods` complete integration periods at the present exponent, stopping at `target_log2`. A `ramp_periods` value of 0 behaves as 1.
- R7: The exponent range is 0 to MAX_LOG2 (7 by default, giving X128 and a 128-field spacing). A target above MAX_LOG2 is clamped.
- R8: When `lowlight_en` is low at a field tick, that tick produces a transfer even in mid-period, and the multiplier returns to X1.
- R9: If `target_log2` is lowered below the current exponent, the running period completes at its old length and the exponent then drops straight to the new target.
- R10: At each field tick the hold flag is updated to 1 if the multiplier is above X1 and that tick did not produce a transfer, and to 0 otherwise. It changes only on field ticks, so it is never high together with a transfer pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| field_tick | input | 1 | One-cycle pulse per video field |
| lowlight_en | input | 1 | Enables extended integration |
| target_log2 | input | LVL_W (3) | Requested exponent k, multiplier 2^k |
| ramp_periods | input | RAMP_W (4) | Complete periods per doubling step (0 acts as 1) |
| xfer_pulse | output | 1 | Shutter / charge-transfer pulse |
| frame_upd | output | 1 | Frame-buffer refresh strobe |
| hold | output | 1 | Keep the previously displayed frame |

## Verification
The bench uses the defaults: MAX_LOG2 = 7, RAMP_W = 4 and registered outputs. With these values a full ramp from X1 to X128 takes 127 fields plus two 128-field periods, which fits easily in the run, so the largest spacing is checked directly. The four-bit ramp input lets the bench try the zero-as-one case alongside ramp values of 1, 2 and 3. Directed scenarios cover leaving low-light mode in mid-period and lowering the target at X8.

// File: rtl/shtr_pkg.sv
package shtr_pkg;

   // Per-field decision handed from the counter to the output stage
   typedef struct packed {
      logic tick;
      logic fire;
   } field_evt_t;

   // Ramp step count where zero counts as one period
   function automatic int unsigned eff_ramp(input int unsigned r);
      return (r == 0) ? 1 : r;
   endfunction

endpackage

// File: rtl/shtr_mask_gen.sv
// Builds 2^level - 1 as a thermometer mask: bit i set when i < level.
module shtr_mask_gen #(
   parameter int MAX_LOG2 = 7,
   parameter int LVL_W    = 3
) (
   input  logic [LVL_W-1:0]    level,
   output logic [MAX_LOG2-1:0] limit
);
   for (genvar i = 0; i < MAX_LOG2; i++) begin : g_bit
      assign limit[i] = (LVL_W'(i) < level);
   end
endmodule

// File: rtl/shtr_field_cnt.sv
// Counts fields since the last transfer; fires when count reaches limit.
module shtr_field_cnt #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] limit,
   output logic             fire
);
   logic [CNT_W-1:0] cnt_q;

   // >= lets a shortened limit (low-light exit) end the period at once
   assign fire = (cnt_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (tick) begin
         if (fire) cnt_q <= '0;
         else      cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/shtr_ramp_ctrl.sv
// Holds the current exponent and steps it toward the target.
module shtr_ramp_ctrl
   import shtr_pkg::*;
#(
   parameter int MAX_LOG2 = 7,
   parameter int LVL_W    = 3,
   parameter int RAMP_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              fire,
   input  logic              lowlight,
   input  logic [LVL_W-1:0]  target,
   input  logic [RAMP_W-1:0] ramp,
   output logic [LVL_W-1:0]  eff_level
);
   localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(MAX_LOG2);

   logic [LVL_W-1:0]  level_q;
   logic [RAMP_W-1:0] per_q;
   logic [LVL_W-1:0]  tgt_c;
   logic [RAMP_W:0]   per_next;
   logic [RAMP_W:0]   ramp_n;

   assign tgt_c     = (target > LVL_MAX) ? LVL_MAX : target;
   assign eff_level = lowlight ? level_q : '0;
   assign per_next  = {1'b0, per_q} + 1'b1;
   assign ramp_n    = (RAMP_W+1)'(eff_ramp(int'(ramp)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= '0;
         per_q   <= '0;
      end else if (tick) begin
         if (!lowlight) begin
            level_q <= '0;
            per_q   <= '0;
         end else if (fire) begin
            if (level_q > tgt_c) begin
               level_q <= tgt_c;
               per_q   <= '0;
            end else if (level_q < tgt_c) begin
               if (per_next >= ramp_n) begin
                  level_q <= level_q + 1'b1;
                  per_q   <= '0;
               end else begin
                  per_q   <= per_next[RAMP_W-1:0];
               end
            end else begin
               per_q <= '0;
            end
         end
      end
   end
endmodule

// File: rtl/shtr_strobe.sv
// Output stage: transfer / update strobes and the per-field hold flag.
module shtr_strobe
   import shtr_pkg::*;
#(
   parameter bit REG_OUT = 1'b1,
   parameter int LVL_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  field_evt_t       evt,
   input  logic [LVL_W-1:0] eff_level,
   output logic             xfer,
   output logic             upd,
   output logic             hold
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        hold <= 1'b0;
      else if (evt.tick) hold <= (eff_level != '0) && !evt.fire;
   end

   if (REG_OUT) begin : g_reg
      logic xfer_q, upd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            xfer_q <= 1'b0;
            upd_q  <= 1'b0;
         end else begin
            xfer_q <= evt.tick & evt.fire;
            upd_q  <= evt.tick & evt.fire;
         end
      end
      assign xfer = xfer_q;
      assign upd  = upd_q;
   end else begin : g_comb
      assign xfer = evt.tick & evt.fire;
      assign upd  = evt.tick & evt.fire;
   end
endmodule

// File: rtl/shutter_ext_timer.sv
module shutter_ext_timer
   import shtr_pkg::*;
#(
   parameter int MAX_LOG2 = 7,
   parameter int RAMP_W   = 4,
   parameter bit REG_OUT  = 1'b1,
   localparam int LVL_W   = $clog2(MAX_LOG2 + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              field_tick,
   input  logic              lowlight_en,
   input  logic [LVL_W-1:0]  target_log2,
   input  logic [RAMP_W-1:0] ramp_periods,
   output logic              xfer_pulse,
   output logic              frame_upd,
   output logic              hold
);
   if (MAX_LOG2 < 1 || MAX_LOG2 > 24) begin : g_bad_max
      $error("MAX_LOG2 out of range");
   end
   if (RAMP_W < 1) begin : g_bad_ramp
      $error("RAMP_W must be at least 1");
   end

   logic [LVL_W-1:0]    eff_level;
   logic [MAX_LOG2-1:0] limit;
   logic                fire;
   field_evt_t          evt;

   shtr_mask_gen #(.MAX_LOG2(MAX_LOG2), .LVL_W(LVL_W)) u_mask (
      .level (eff_level),
      .limit (limit)
   );

   shtr_field_cnt #(.CNT_W(MAX_LOG2)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (field_tick),
      .limit (limit),
      .fire  (fire)
   );

   shtr_ramp_ctrl #(.MAX_LOG2(MAX_LOG2), .LVL_W(LVL_W), .RAMP_W(RAMP_W)) u_ramp (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (field_tick),
      .fire      (fire),
      .lowlight  (lowlight_en),
      .target    (target_log2),
      .ramp      (ramp_periods),
      .eff_level (eff_level)
   );

   assign evt.tick = field_tick;
   assign evt.fire = fire;

   shtr_strobe #(.REG_OUT(REG_OUT), .LVL_W(LVL_W)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt       (evt),
      .eff_level (eff_level),
      .xfer      (xfer_pulse),
      .upd       (frame_upd),
      .hold      (hold)
   );
endmodule

// File: rtl/shtr_checker.sv
module shtr_checker #(
   parameter bit REG_OUT = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic field_tick,
   input logic lowlight_en,
   input logic xfer_pulse,
   input logic frame_upd,
   input logic hold
);
   if (REG_OUT) begin : g_reg_props
      assert_xfer_after_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
         xfer_pulse |-> $past(field_tick));

      assert_every_field_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (field_tick && !lowlight_en) |=> xfer_pulse);

      assert_hold_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
         !field_tick |=> $stable(hold));
   end

   assert_upd_with_xfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
      frame_upd == xfer_pulse);

   assert_no_hold_on_xfer_R10: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_pulse |-> !hold);
endmodule

bind shutter_ext_timer shtr_checker #(.REG_OUT(REG_OUT)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .field_tick  (field_tick),
   .lowlight_en (lowlight_en),
   .xfer_pulse  (xfer_pulse),
   .frame_upd   (frame_upd),
   .hold        (hold)
);

// File: tb/tb_shutter_ext_timer.sv
`timescale 1ns/1ps
module tb_shutter_ext_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       field_tick = 1'b0;
   logic       lowlight_en = 1'b0;
   logic [2:0] target_log2 = '0;
   logic [3:0] ramp_periods = 4'd1;
   logic       xfer_pulse, frame_upd, hold;

   int n_run = 0;
   int n_fail = 0;
   int n_x = 0;
   int last_gap = 0;
   int since = 0;
   bit last_got = 1'b0;

   always #2.5 clk = ~clk;

   shutter_ext_timer dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .field_tick   (field_tick),
      .lowlight_en  (lowlight_en),
      .target_log2  (target_log2),
      .ramp_periods (ramp_periods),
      .xfer_pulse   (xfer_pulse),
      .frame_upd    (frame_upd),
      .hold         (hold)
   );

   typedef struct packed {
      logic        ll;
      logic [2:0]  tgt;
      logic [3:0]  rmp;
      logic [15:0] nf;
      logic [15:0] nx;
      logic [15:0] gap;
   } vec_t;

   // lowlight, target, ramp, fields, expected transfers, expected last spacing
   localparam vec_t VECS [7] = '{
      '{1'b0, 3'd5, 4'd1, 16'd20,  16'd20, 16'd1},   // R2
      '{1'b1, 3'd0, 4'd3, 16'd10,  16'd10, 16'd1},   // R5 X1
      '{1'b1, 3'd1, 4'd1, 16'd11,  16'd6,  16'd2},   // R5 R6
      '{1'b1, 3'd2, 4'd2, 16'd20,  16'd7,  16'd4},   // R6 two periods per step
      '{1'b1, 3'd3, 4'd1, 16'd15,  16'd4,  16'd8},   // R6
      '{1'b1, 3'd7, 4'd1, 16'd383, 16'd9,  16'd128}, // R7 X128
      '{1'b1, 3'd2, 4'd0, 16'd7,   16'd3,  16'd4}    // R6 zero acts as one
   };

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      field_tick = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      n_x = 0; last_gap = 0; since = 0;
   endtask

   // One field: tick for a cycle, then two idle cycles.
   task automatic one_field();
      @(negedge clk) field_tick = 1'b1;
      @(negedge clk) field_tick = 1'b0;
      last_got = xfer_pulse;
      if (frame_upd !== xfer_pulse) chk("R3 upd/xfer", int'(frame_upd), int'(xfer_pulse));
      if (hold !== !xfer_pulse)     chk("R10 hold", int'(hold), int'(!xfer_pulse));
      since++;
      if (last_got) begin
         if (n_x > 0) last_gap = since;
         n_x++;
         since = 0;
      end
      @(negedge clk);
      if (xfer_pulse !== 1'b0) chk("R4 idle xfer", int'(xfer_pulse), 0);
      @(negedge clk);
   endtask

   task automatic run_fields(input int n);
      for (int i = 0; i < n; i++) one_field();
   endtask

   initial begin
      #(100000 * 5);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      do_reset();
      // R1 reset state
      chk("R1 xfer", int'(xfer_pulse), 0);
      chk("R1 upd", int'(frame_upd), 0);
      chk("R1 hold", int'(hold), 0);

      // Table walk
      for (int v = 0; v < 7; v++) begin
         lowlight_en  = VECS[v].ll;
         target_log2  = VECS[v].tgt;
         ramp_periods = VECS[v].rmp;
         do_reset();
         run_fields(int'(VECS[v].nf));
         chk($sformatf("R5/R6 count vec%0d", v), n_x, int'(VECS[v].nx));
         chk($sformatf("R5/R7 spacing vec%0d", v), last_gap, int'(VECS[v].gap));
      end

      // R4: no ticks, no transfer
      repeat (40) begin
         @(negedge clk);
         if (xfer_pulse !== 1'b0) chk("R4 no tick", int'(xfer_pulse), 0);
      end
      chk("R4 quiet", int'(xfer_pulse), 0);

      // R8: leave low-light mid-period at X8
      lowlight_en = 1'b1; target_log2 = 3'd3; ramp_periods = 4'd1;
      do_reset();
      run_fields(7);
      run_fields(3);
      chk("R10 hold mid-period", int'(hold), 1);
      chk("R8 no xfer yet", n_x, 3);
      lowlight_en = 1'b0;
      one_field();
      chk("R8 exit xfer", int'(last_got), 1);
      one_field();
      chk("R8 back to X1", int'(last_got), 1);
      chk("R10 hold at X1", int'(hold), 0);

      // R9: lower target at X8 mid-period
      lowlight_en = 1'b1; target_log2 = 3'd3;
      do_reset();
      run_fields(7);
      run_fields(3);
      target_log2 = 3'd1;
      n_x = 0;
      run_fields(4);
      chk("R9 period continues", n_x, 0);
      one_field();
      chk("R9 old length done", int'(last_got), 1);
      one_field();
      chk("R9 first at new", int'(last_got), 0);
      one_field();
      chk("R9 spacing now 2", last_gap, 2);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule